// File: doc/BRIEF.md
# Staged Hold-to-Reset Controller

This block watches two debounced, active-low key levels (a power key and a dedicated reset key) and derives three reset sources from them: the power key alone, the reset key alone, and both keys held together. When an enabled source is held, a single shared sequencer runs two cascaded stages timed in 1 ms ticks. The end of the first stage raises a bark interrupt for that source. Holding on to the end of the second stage strobes a reset request towards the power sequencer, carrying a 3-bit reset type.

Each source has its own enable, its own 4-bit first-stage code and 3-bit second-stage code, both picked from fixed non-uniform duration tables, and its own reset type. The combined source outranks the single sources. A register records the source and type of the most recent reset request, and software clears it with a write-one strobe. Press and release pulses for both physical keys are always reported, whatever the configuration.

Top module: `hold_reset_ctrl`

## Requirements
- R1: Source 0 is held while `keyPwrN` is low, source 1 while `keyRstN` is low, and source 2 while both are low. A source is eligible only while it is held, its `cfgEn` bit is set, and its type is valid.
- R2: Stage-1 code values 0 to 15 select 0, 32, 56, 80, 128, 184, 272, 408, 608, 904, 1352, 2048, 3072, 4480, 6720 and 10256 ticks. A stage of duration D expires on the (D+1)-th tick after it is entered, so D = 0 expires on the first tick. No time passes in cycles where `tick` is low.
- R3: Stage-2 code values 0 to 7 select 0, 10, 50, 100, 250, 500, 1000 and 2000 ticks. Stage 2 starts from zero at the tick on which stage 1 expires. With `tick` high on every cycle and the press sampled at edge 0, the reset request appears at edge D1+D2+2.
- R4: When stage 1 expires, `barkIrq` is high for one cycle, with only bit `src` set. When stage 2 expires, `rstReq` is high for one cycle and `rstType` holds that source's type.
- R5: The valid reset type codes are soft = 0, warm = 1, shutdown = 4 and hard = 7. A source with any other type code is treated as disabled.
- R6: A source whose `cfgEn` bit is clear never starts the stages, whatever its durations are.
- R7: When `sysCtl` is low, bark interrupts are suppressed, but stage timing and the reset request are unchanged.
- R8: Releasing the active source before stage 2 expires returns the sequencer to idle. No bark or reset follows, and the next press starts again from zero.
- R9: The combined source has priority. If both keys are eligible at once, source 2 runs. A running single-source sequence is aborted and restarted as source 2 once source 2 becomes eligible. If source 2 is not eligible, source 0 is preferred over source 1.
- R10: Each reset request sets `reasonValid` and latches `reasonSrc` (0 = power, 1 = reset key, 2 = combined) and `reasonType`. A one-cycle pulse on `reasonClr` clears all three fields. A new request in the same cycle takes precedence over the clear.
- R11: After reset, every output is zero.
- R12: `pressEvt[k]` and `releaseEvt[k]` pulse for one cycle, one edge after the falling or rising level of key k (bit 0 = power, bit 1 = reset key). They pulse regardless of enable or type.
- R13: After a reset request, the sequencer issues nothing more until the active source is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| keyPwrN | input | 1 | Debounced power key level, low = pressed |
| keyRstN | input | 1 | Debounced reset key level, low = pressed |
| tick | input | 1 | 1 ms time-base strobe |
| sysCtl | input | 1 | Block acts as system reset controller (bark enable) |
| cfgEn | input | 3 | Per-source reset enable |
| cfgS1Code | input | 12 | Stage-1 codes, 4 bits per source |
| cfgS2Code | input | 9 | Stage-2 codes, 3 bits per source |
| cfgType | input | 9 | Reset types, 3 bits per source |
| reasonClr | input | 1 | Write-one clear of the reason register |
| barkIrq | output | 3 | Per-source bark pulse |
| rstReq | output | 1 | Reset request strobe |
| rstType | output | 3 | Type of the reset request |
| reasonValid | output | 1 | Reason register holds a request |
| reasonSrc | output | 2 | Source of the last request |
| reasonType | output | 3 | Type of the last request |
| pressEvt | output | 2 | Key press pulses |
| releaseEvt | output | 2 | Key release pulses |

## Verification
The bench builds the block with its default counter width of 14 bits and drives `tick` high on every cycle, except in one test that stalls it. This brings every one of the sixteen stage-1 codes, up to the 10256-tick maximum, and all eight stage-2 codes within reach of exact cycle counts computed in the bench. All eight type codes are swept, and dedicated sequences cover release in each stage, combined-source preemption, suppressed barks and the reason clear.

// File: rtl/hold_reset_pkg.sv
package hold_reset_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_W   = 2;
  localparam int S1_W    = 4;
  localparam int S2_W    = 3;
  localparam int TYPE_W  = 3;
  localparam int DUR_W   = 14;
  localparam int KEY_N   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_STG1, ST_STG2, ST_DONE} stage_e;

  typedef struct packed {
    logic             cntClr;
    logic             cntInc;
    logic             useStg2;
    logic             barkFire;
    logic             rstFire;
    logic [SRC_W-1:0] src;
  } ctrl_strobe_t;

  function automatic logic [DUR_W-1:0] s1Ticks(input logic [S1_W-1:0] c);
    case (c)
      4'd0:  return 14'd0;
      4'd1:  return 14'd32;
      4'd2:  return 14'd56;
      4'd3:  return 14'd80;
      4'd4:  return 14'd128;
      4'd5:  return 14'd184;
      4'd6:  return 14'd272;
      4'd7:  return 14'd408;
      4'd8:  return 14'd608;
      4'd9:  return 14'd904;
      4'd10: return 14'd1352;
      4'd11: return 14'd2048;
      4'd12: return 14'd3072;
      4'd13: return 14'd4480;
      4'd14: return 14'd6720;
      default: return 14'd10256;
    endcase
  endfunction

  function automatic logic [DUR_W-1:0] s2Ticks(input logic [S2_W-1:0] c);
    case (c)
      3'd0: return 14'd0;
      3'd1: return 14'd10;
      3'd2: return 14'd50;
      3'd3: return 14'd100;
      3'd4: return 14'd250;
      3'd5: return 14'd500;
      3'd6: return 14'd1000;
      default: return 14'd2000;
    endcase
  endfunction

  function automatic logic typeValid(input logic [TYPE_W-1:0] t);
    return (t == 3'd0) || (t == 3'd1) || (t == 3'd4) || (t == 3'd7);
  endfunction
endpackage

// File: rtl/hold_reset_ctrl_fsm.sv
module hold_reset_ctrl_fsm
  import hold_reset_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        keyPwrN,
  input  logic                        keyRstN,
  input  logic                        tick,
  input  logic [NUM_SRC-1:0]          cfgEn,
  input  logic [NUM_SRC*TYPE_W-1:0]   cfgType,
  input  logic                        expired,
  output ctrl_strobe_t                strobe
);
  localparam logic [SRC_W-1:0] SRC_COMBO = SRC_W'(NUM_SRC - 1);

  logic [NUM_SRC-1:0] held;
  logic [NUM_SRC-1:0] elig;
  logic [SRC_W-1:0]   pick;
  logic [SRC_W-1:0]   srcQ, srcD;
  stage_e             state, stateD;

  assign held[0] = !keyPwrN;
  assign held[1] = !keyRstN;
  assign held[2] = !keyPwrN && !keyRstN;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = held[i] && cfgEn[i] && typeValid(cfgType[i*TYPE_W +: TYPE_W]);
  end

  always_comb begin
    if (elig[2])      pick = SRC_COMBO;
    else if (elig[0]) pick = 2'd0;
    else              pick = 2'd1;
  end

  always_comb begin
    stateD         = state;
    srcD           = srcQ;
    strobe         = '0;
    strobe.src     = srcQ;
    strobe.useStg2 = (state == ST_STG2);
    case (state)
      ST_IDLE: begin
        if (|elig) begin
          stateD        = ST_STG1;
          srcD          = pick;
          strobe.cntClr = 1'b1;
        end
      end
      ST_STG1, ST_STG2: begin
        if (!elig[srcQ]) begin
          stateD        = ST_IDLE;
          strobe.cntClr = 1'b1;
        end else if (srcQ != SRC_COMBO && elig[2]) begin
          stateD        = ST_STG1;
          srcD          = SRC_COMBO;
          strobe.cntClr = 1'b1;
        end else if (tick) begin
          if (expired) begin
            strobe.cntClr = 1'b1;
            if (state == ST_STG1) begin
              stateD          = ST_STG2;
              strobe.barkFire = 1'b1;
            end else begin
              stateD         = ST_DONE;
              strobe.rstFire = 1'b1;
            end
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      default: begin
        if (!elig[srcQ]) stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      srcQ  <= '0;
    end else begin
      state <= stateD;
      srcQ  <= srcD;
    end
  end

  // R3: stage 2 is never entered straight from idle
  assert_stage_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> (state != ST_STG2));

  // R8: losing the active source while timing returns to idle
  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_STG1 || state == ST_STG2) && !elig[srcQ]) |=> (state == ST_IDLE));

  // R9: combined source preempts a running single-source sequence
  assert_combo_preempt_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_STG1 || state == ST_STG2) && srcQ != SRC_COMBO && elig[srcQ] && elig[2])
    |=> (state == ST_STG1 && srcQ == SRC_COMBO));
endmodule

// File: rtl/hold_reset_ctrl_dp.sv
module hold_reset_ctrl_dp
  import hold_reset_pkg::*;
#(
  parameter int CNT_W = DUR_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        keyPwrN,
  input  logic                        keyRstN,
  input  logic                        sysCtl,
  input  logic [NUM_SRC*S1_W-1:0]     cfgS1Code,
  input  logic [NUM_SRC*S2_W-1:0]     cfgS2Code,
  input  logic [NUM_SRC*TYPE_W-1:0]   cfgType,
  input  logic                        reasonClr,
  input  ctrl_strobe_t                strobe,
  output logic                        expired,
  output logic [NUM_SRC-1:0]          barkIrq,
  output logic                        rstReq,
  output logic [TYPE_W-1:0]           rstType,
  output logic                        reasonValid,
  output logic [SRC_W-1:0]            reasonSrc,
  output logic [TYPE_W-1:0]           reasonType,
  output logic [KEY_N-1:0]            pressEvt,
  output logic [KEY_N-1:0]            releaseEvt
);
  logic [S1_W-1:0]   s1Arr   [NUM_SRC];
  logic [S2_W-1:0]   s2Arr   [NUM_SRC];
  logic [TYPE_W-1:0] typeArr [NUM_SRC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_unpack
    assign s1Arr[i]   = cfgS1Code[i*S1_W +: S1_W];
    assign s2Arr[i]   = cfgS2Code[i*S2_W +: S2_W];
    assign typeArr[i] = cfgType[i*TYPE_W +: TYPE_W];
  end

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] durSel;
  logic [TYPE_W-1:0] typeSel;

  assign durSel  = strobe.useStg2 ? CNT_W'(s2Ticks(s2Arr[strobe.src]))
                                  : CNT_W'(s1Ticks(s1Arr[strobe.src]));
  assign typeSel = typeArr[strobe.src];
  assign expired = (cnt >= durSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      barkIrq <= '0;
      rstReq  <= 1'b0;
      rstType <= '0;
    end else begin
      barkIrq <= (strobe.barkFire && sysCtl) ? (NUM_SRC'(1) << strobe.src) : '0;
      rstReq  <= strobe.rstFire;
      rstType <= strobe.rstFire ? typeSel : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reasonValid <= 1'b0;
      reasonSrc   <= '0;
      reasonType  <= '0;
    end else if (strobe.rstFire) begin
      reasonValid <= 1'b1;
      reasonSrc   <= strobe.src;
      reasonType  <= typeSel;
    end else if (reasonClr) begin
      reasonValid <= 1'b0;
      reasonSrc   <= '0;
      reasonType  <= '0;
    end
  end

  logic [KEY_N-1:0] keyHeld, keyPrev;
  assign keyHeld = {!keyRstN, !keyPwrN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyPrev    <= '0;
      pressEvt   <= '0;
      releaseEvt <= '0;
    end else begin
      keyPrev    <= keyHeld;
      pressEvt   <= keyHeld & ~keyPrev;
      releaseEvt <= ~keyHeld & keyPrev;
    end
  end

  // R4: at most one bark bit at a time, and each strobe lasts one cycle
  assert_bark_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(barkIrq));
  assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  // R5: only the four legal type codes leave the block
  assert_type_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> typeValid(rstType));
  // R7: no bark while not acting as system reset controller
  assert_bark_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sysCtl |=> (barkIrq == '0));
  // R10: reason register agrees with the request it captured
  assert_reason_latch_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> (reasonValid && reasonType == rstType));
endmodule

// File: rtl/hold_reset_ctrl.sv
module hold_reset_ctrl
  import hold_reset_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         keyPwrN,
  input  logic         keyRstN,
  input  logic         tick,
  input  logic         sysCtl,
  input  logic [2:0]   cfgEn,
  input  logic [11:0]  cfgS1Code,
  input  logic [8:0]   cfgS2Code,
  input  logic [8:0]   cfgType,
  input  logic         reasonClr,
  output logic [2:0]   barkIrq,
  output logic         rstReq,
  output logic [2:0]   rstType,
  output logic         reasonValid,
  output logic [1:0]   reasonSrc,
  output logic [2:0]   reasonType,
  output logic [1:0]   pressEvt,
  output logic [1:0]   releaseEvt
);
  ctrl_strobe_t strobe;
  logic         expired;

  hold_reset_ctrl_fsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .keyPwrN (keyPwrN),
    .keyRstN (keyRstN),
    .tick    (tick),
    .cfgEn   (cfgEn),
    .cfgType (cfgType),
    .expired (expired),
    .strobe  (strobe)
  );

  hold_reset_ctrl_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .keyPwrN     (keyPwrN),
    .keyRstN     (keyRstN),
    .sysCtl      (sysCtl),
    .cfgS1Code   (cfgS1Code),
    .cfgS2Code   (cfgS2Code),
    .cfgType     (cfgType),
    .reasonClr   (reasonClr),
    .strobe      (strobe),
    .expired     (expired),
    .barkIrq     (barkIrq),
    .rstReq      (rstReq),
    .rstType     (rstType),
    .reasonValid (reasonValid),
    .reasonSrc   (reasonSrc),
    .reasonType  (reasonType),
    .pressEvt    (pressEvt),
    .releaseEvt  (releaseEvt)
  );
endmodule

// File: tb/hold_reset_ctrl_bench.sv
module hold_reset_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyPwrN = 1'b1, keyRstN = 1'b1, tick = 1'b1, sysCtl = 1'b1, reasonClr = 1'b0;
  logic [2:0]  cfgEn = 3'b000;
  logic [11:0] cfgS1Code = '0;
  logic [8:0]  cfgS2Code = '0;
  logic [8:0]  cfgType = '0;
  logic [2:0]  barkIrq, rstType, reasonType;
  logic        rstReq, reasonValid;
  logic [1:0]  reasonSrc, pressEvt, releaseEvt;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  hold_reset_ctrl u_hold_reset_ctrl (
    .clk(clk), .rstN(rstN), .keyPwrN(keyPwrN), .keyRstN(keyRstN), .tick(tick),
    .sysCtl(sysCtl), .cfgEn(cfgEn), .cfgS1Code(cfgS1Code), .cfgS2Code(cfgS2Code),
    .cfgType(cfgType), .reasonClr(reasonClr), .barkIrq(barkIrq), .rstReq(rstReq),
    .rstType(rstType), .reasonValid(reasonValid), .reasonSrc(reasonSrc),
    .reasonType(reasonType), .pressEvt(pressEvt), .releaseEvt(releaseEvt));

  function automatic int s1Ms(input int c);
    int tbl [16] = '{0, 32, 56, 80, 128, 184, 272, 408, 608, 904, 1352, 2048, 3072, 4480, 6720, 10256};
    return tbl[c];
  endfunction

  function automatic int s2Ms(input int c);
    int tbl [8] = '{0, 10, 50, 100, 250, 500, 1000, 2000};
    return tbl[c];
  endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setSrc(input int s, input int s1, input int s2, input int ty);
    cfgS1Code[s*4 +: 4] = 4'(s1);
    cfgS2Code[s*3 +: 3] = 3'(s2);
    cfgType[s*3 +: 3]   = 3'(ty);
  endtask

  task automatic releaseKeys();
    @(negedge clk);
    keyPwrN = 1'b1;
    keyRstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(input int src, input int limit, input int holdAfter,
                         output int kBark, output int kRst, output int barkVec,
                         output int typ, output int extra);
    kBark = -1; kRst = -1; barkVec = 0; typ = -1; extra = 0;
    @(negedge clk);
    if (src != 1) keyPwrN = 1'b0;
    if (src != 0) keyRstN = 1'b0;
    for (int k = 0; k <= limit; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (barkIrq != 0 && kBark < 0) begin kBark = k; barkVec = int'(barkIrq); end
      if (rstReq) begin kRst = k; typ = int'(rstType); break; end
    end
    for (int j = 0; j < holdAfter; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (rstReq || barkIrq != 0) extra++;
    end
    releaseKeys();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int kb, kr, bv, ty, ex, seen;
    repeat (4) @(negedge clk);
    // R11: outputs after reset
    checkEq("R11 bark", int'(barkIrq), 0);
    checkEq("R11 rstReq", int'(rstReq), 0);
    checkEq("R11 reason", int'({reasonValid, reasonSrc, reasonType}), 0);
    checkEq("R11 events", int'({pressEvt, releaseEvt}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: full stage-1 sweep on the power key, stage 2 zero
    cfgEn = 3'b111;
    for (int c = 0; c < 16; c++) begin
      setSrc(0, c, 0, 1);
      measure(0, 12000, 0, kb, kr, bv, ty, ex);
      checkEq("R2 bark time", kb, s1Ms(c) + 1);
      checkEq("R3 reset time", kr, s1Ms(c) + 2);
      checkEq("R4 bark bit", bv, 1);
    end

    // R3: full stage-2 sweep on the reset key, stage 1 zero
    for (int c = 0; c < 8; c++) begin
      setSrc(1, 0, c, 4);
      measure(1, 3000, 0, kb, kr, bv, ty, ex);
      checkEq("R3 bark time", kb, 1);
      checkEq("R3 reset time", kr, s2Ms(c) + 2);
      checkEq("R4 bark bit", bv, 2);
      checkEq("R4 type", ty, 4);
    end
    // R10: reason captures source 1, type 4, and clears on write-one
    checkEq("R10 valid", int'(reasonValid), 1);
    checkEq("R10 src", int'(reasonSrc), 1);
    checkEq("R10 type", int'(reasonType), 4);
    @(negedge clk); reasonClr = 1'b1;
    @(negedge clk); reasonClr = 1'b0;
    checkEq("R10 cleared", int'({reasonValid, reasonSrc, reasonType}), 0);

    // R5: every type code; only 0,1,4,7 start a sequence
    for (int t = 0; t < 8; t++) begin
      setSrc(0, 0, 0, t);
      measure(0, 20, 0, kb, kr, bv, ty, ex);
      if (t == 0 || t == 1 || t == 4 || t == 7) begin
        checkEq("R5 valid reset time", kr, 2);
        checkEq("R5 valid type", ty, t);
      end else begin
        checkEq("R5 invalid no bark", kb, -1);
        checkEq("R5 invalid no reset", kr, -1);
      end
    end

    // R13: holding on after a request yields nothing more
    setSrc(0, 0, 0, 7);
    measure(0, 20, 30, kb, kr, bv, ty, ex);
    checkEq("R13 first reset", kr, 2);
    checkEq("R13 extra events", ex, 0);

    // R7: barks suppressed, reset timing kept
    sysCtl = 1'b0;
    setSrc(0, 0, 2, 1);
    measure(0, 200, 0, kb, kr, bv, ty, ex);
    checkEq("R7 no bark", kb, -1);
    checkEq("R7 reset time", kr, 52);
    sysCtl = 1'b1;

    // R6 + R12: disabled source reports edges but never times
    cfgEn = 3'b110;
    @(negedge clk); keyPwrN = 1'b0;
    @(posedge clk); @(negedge clk);
    checkEq("R12 press power", int'(pressEvt), 1);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); @(negedge clk);
      if (barkIrq != 0 || rstReq) seen++;
    end
    checkEq("R6 disabled no activity", seen, 0);
    keyPwrN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkEq("R12 release power", int'(releaseEvt), 1);
    keyRstN = 1'b0;
    @(posedge clk); @(negedge clk);
    checkEq("R12 press reset key", int'(pressEvt), 2);
    keyRstN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkEq("R12 release reset key", int'(releaseEvt), 2);
    repeat (3) @(negedge clk);

    // R9: combined source not enabled -> power key wins
    cfgEn = 3'b011;
    setSrc(0, 0, 0, 1);
    setSrc(1, 0, 0, 4);
    measure(2, 20, 0, kb, kr, bv, ty, ex);
    checkEq("R9 power preferred", bv, 1);

    // R9/R1: combined source enabled and pressed together
    cfgEn = 3'b111;
    setSrc(2, 0, 1, 7);
    measure(2, 50, 0, kb, kr, bv, ty, ex);
    checkEq("R1 combo bark bit", bv, 4);
    checkEq("R1 combo reset time", kr, 12);
    checkEq("R9 combo type", ty, 7);
    checkEq("R10 combo src", int'(reasonSrc), 2);

    // R9: combined press aborts a running power-key sequence
    setSrc(0, 3, 0, 1);
    setSrc(2, 0, 0, 7);
    @(negedge clk); keyPwrN = 1'b0;
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (barkIrq != 0) seen++;
    end
    checkEq("R9 no early bark", seen, 0);
    measure(2, 20, 0, kb, kr, bv, ty, ex);
    checkEq("R9 restart bark time", kb, 1);
    checkEq("R9 restart bark bit", bv, 4);
    checkEq("R9 restart reset time", kr, 2);

    // R8: release during stage 1, then during stage 2
    setSrc(0, 1, 1, 1);
    @(negedge clk); keyPwrN = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (barkIrq != 0 || rstReq) seen++;
    end
    releaseKeys();
    checkEq("R8 stage1 release quiet", seen, 0);
    measure(0, 100, 0, kb, kr, bv, ty, ex);
    checkEq("R8 fresh bark time", kb, 33);
    checkEq("R8 fresh reset time", kr, 44);
    @(negedge clk); keyPwrN = 1'b0;
    kb = -1; seen = 0;
    for (int k = 0; k < 38; k++) begin
      @(posedge clk); @(negedge clk);
      if (barkIrq != 0) kb = k;
      if (rstReq) seen++;
    end
    keyPwrN = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (rstReq) seen++;
    end
    checkEq("R8 stage2 bark seen", kb, 33);
    checkEq("R8 stage2 release no reset", seen, 0);

    // R2: no progress without ticks
    setSrc(0, 0, 0, 1);
    tick = 1'b0;
    @(negedge clk); keyPwrN = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (barkIrq != 0 || rstReq) seen++;
    end
    checkEq("R2 stalled tick", seen, 0);
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    checkEq("R2 first tick bark", int'(barkIrq), 1);
    releaseKeys();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule